// File: doc/BRIEF.md
# Pipelined Bus Register Bank

This block is a small bank of control and status registers behind a pipelined Wishbone slave port with a 32-bit data bus and per-byte selects. Each bus cycle is turned into a read or a write request and served by one of four word-aligned registers. Each register has a fixed access kind: a status word sampled from an input port, a control word that is stored and read back, a command word that can only be written, and a loopback word whose written value drives an output port while reads return a separate input port.

The control and command words each pulse a one-cycle strobe when they are written, so that logic nearby can act on a fresh value. The slave holds the master off with stall until it acknowledges. A parameter selects whether the read path has one registered stage; that stage adds one cycle of read latency and relaxes the timing of the read mux.

Top module: `regbank_wb`

## Requirements
- R1: While the synchronous active-low reset `rstN` is low and in the cycle after it, `ack` is 0, all three output words, both strobes and `datOut` are 0.
- R2: A write request (`cyc`, `stb` and `we` high) raises `ack` in the cycle after it is first presented. The write lands at the same clock edge.
- R3: A read request gives `ack` one cycle after it is presented when `READ_STAGE` is 0 and two cycles after when it is 1, with `datOut` valid in the `ack` cycle. Data is sampled at the edge that accepts the request.
- R4: On writes to word offsets 1, 2 and 3, byte lane k (data bits 8k+7..8k) changes only when `sel[k]` is 1.
- R5: Offset 0 is read-only: reads return `statusIn`, and writes are acknowledged but change no output word.
- R6: Offset 2 is write-only: writes update `cmdOut`, and reads return 0.
- R7: Offset 1 is read-write: writes update `ctrlOut`, and reads return the stored `ctrlOut` value.
- R8: Offset 3 is read-write: writes update `ioOut`, and reads return `ioIn`.
- R9: `ctrlWr` (offset 1) and `cmdWr` (offset 2) pulse high for exactly one cycle on any accepted write to their offset, whatever the byte selects are. The pulse coincides with `ack`.
- R10: Offsets 4 and above are unmapped: reads return 0 and are acknowledged, and writes change no output word.
- R11: Each request is acknowledged exactly once. `ack` never stays high for two consecutive cycles, and it is only given after a request.
- R12: `stall` is high exactly when `cyc` and `stb` are high and `ack` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| cyc | input | 1 | Bus cycle in progress |
| stb | input | 1 | Request strobe |
| we | input | 1 | 1 = write, 0 = read |
| adr | input | ADDR_W | Word offset |
| datIn | input | DATA_W | Write data |
| sel | input | DATA_W/8 | Byte selects |
| ack | output | 1 | Acknowledge |
| stall | output | 1 | Master hold-off |
| datOut | output | DATA_W | Read data |
| statusIn | input | DATA_W | Value returned by offset 0 |
| ioIn | input | DATA_W | Value returned by offset 3 |
| ctrlOut | output | DATA_W | Stored control word (offset 1) |
| cmdOut | output | DATA_W | Stored command word (offset 2) |
| ioOut | output | DATA_W | Stored loopback word (offset 3) |
| ctrlWr | output | 1 | One-cycle write pulse for offset 1 |
| cmdWr | output | 1 | One-cycle write pulse for offset 2 |

## Verification
Write acknowledges, strobes and output words are due one clock after the request is presented. Read acknowledges and read data are due after one clock with no read stage and after two clocks with it. The bench runs one instance of each read-path variant side by side and drops each instance's strobe when that instance acknowledges. It samples shortly after each rising edge and checks the exact cycle in which each result appears. It also checks the cycle before, where `ack` must still be low and `stall` high, and the cycle after, where `ack` must be low again. Input ports are held steady from the moment a request is driven until it is acknowledged, so the sample taken at the accepting edge is known.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

  localparam int OFF_STATUS = 0;
  localparam int OFF_CTRL   = 1;
  localparam int OFF_CMD    = 2;
  localparam int OFF_IO     = 3;

  typedef struct packed {
    logic wrGo;     // write accepted this cycle
    logic rdGo;     // read accepted this cycle
    logic rdShift;  // first read stage moves to output stage
  } ctlStrobes_t;

endpackage

// File: rtl/regbank_ctrl.sv
module regbank_ctrl #(
  parameter int READ_STAGE = 1
) (
  input  logic clk,
  input  logic rstN,
  input  logic cyc,
  input  logic stb,
  input  logic we,
  output logic ack,
  output logic stall,
  output regbank_pkg::ctlStrobes_t ctl
);

  logic busEn;
  logic rdReq;
  logic wrReq;
  logic wrAck;
  logic rdAck;
  logic rdAck1;
  logic ackInt;
  logic busy;

  assign busEn  = cyc & stb;
  assign rdReq  = busEn & ~we;
  assign wrReq  = busEn & we;
  assign ackInt = rdAck | wrAck;
  assign busy   = ackInt | rdAck1;

  assign ctl.wrGo    = wrReq & ~busy;
  assign ctl.rdGo    = rdReq & ~busy;
  assign ctl.rdShift = rdAck1;

  always_ff @(posedge clk) begin
    if (!rstN) wrAck <= 1'b0;
    else       wrAck <= ctl.wrGo;
  end

  generate
    if (READ_STAGE != 0) begin : g_rdStaged
      always_ff @(posedge clk) begin
        if (!rstN) begin
          rdAck1 <= 1'b0;
          rdAck  <= 1'b0;
        end else begin
          rdAck1 <= ctl.rdGo;
          rdAck  <= rdAck1;
        end
      end
    end else begin : g_rdDirect
      assign rdAck1 = 1'b0;
      always_ff @(posedge clk) begin
        if (!rstN) rdAck <= 1'b0;
        else       rdAck <= ctl.rdGo;
      end
    end
  endgenerate

  assign ack   = ackInt;
  assign stall = busEn & ~ackInt;

endmodule

// File: rtl/regbank_dp.sv
module regbank_dp #(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 3,
  parameter int READ_STAGE = 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  regbank_pkg::ctlStrobes_t ctl,
  input  logic [ADDR_W-1:0]       adr,
  input  logic [DATA_W-1:0]       datIn,
  input  logic [DATA_W/8-1:0]     sel,
  input  logic [DATA_W-1:0]       statusIn,
  input  logic [DATA_W-1:0]       ioIn,
  output logic [DATA_W-1:0]       datOut,
  output logic [DATA_W-1:0]       ctrlOut,
  output logic [DATA_W-1:0]       cmdOut,
  output logic [DATA_W-1:0]       ioOut,
  output logic                    ctrlWr,
  output logic                    cmdWr
);
  import regbank_pkg::*;

  localparam int BYTES = DATA_W / 8;

  logic [DATA_W-1:0] ctrlReg;
  logic [DATA_W-1:0] cmdReg;
  logic [DATA_W-1:0] ioReg;
  logic [DATA_W-1:0] laneMask;
  logic [DATA_W-1:0] rdMux;
  logic              hitCtrl;
  logic              hitCmd;
  logic              hitIo;

  genvar b;
  generate
    for (b = 0; b < BYTES; b++) begin : g_lane
      assign laneMask[8*b +: 8] = {8{sel[b]}};
    end
  endgenerate

  assign hitCtrl = (adr == ADDR_W'(OFF_CTRL));
  assign hitCmd  = (adr == ADDR_W'(OFF_CMD));
  assign hitIo   = (adr == ADDR_W'(OFF_IO));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= '0;
      cmdReg  <= '0;
      ioReg   <= '0;
      ctrlWr  <= 1'b0;
      cmdWr   <= 1'b0;
    end else begin
      ctrlWr <= ctl.wrGo & hitCtrl;
      cmdWr  <= ctl.wrGo & hitCmd;
      if (ctl.wrGo && hitCtrl) ctrlReg <= (ctrlReg & ~laneMask) | (datIn & laneMask);
      if (ctl.wrGo && hitCmd)  cmdReg  <= (cmdReg  & ~laneMask) | (datIn & laneMask);
      if (ctl.wrGo && hitIo)   ioReg   <= (ioReg   & ~laneMask) | (datIn & laneMask);
    end
  end

  always_comb begin
    case (adr)
      ADDR_W'(OFF_STATUS): rdMux = statusIn;
      ADDR_W'(OFF_CTRL):   rdMux = ctrlReg;
      ADDR_W'(OFF_IO):     rdMux = ioIn;
      default:             rdMux = '0;
    endcase
  end

  generate
    if (READ_STAGE != 0) begin : g_rdPipe
      logic [DATA_W-1:0] rdStage;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          rdStage <= '0;
          datOut  <= '0;
        end else begin
          if (ctl.rdGo)    rdStage <= rdMux;
          if (ctl.rdShift) datOut  <= rdStage;
        end
      end
    end else begin : g_rdFlat
      always_ff @(posedge clk) begin
        if (!rstN)         datOut <= '0;
        else if (ctl.rdGo) datOut <= rdMux;
      end
    end
  endgenerate

  assign ctrlOut = ctrlReg;
  assign cmdOut  = cmdReg;
  assign ioOut   = ioReg;

endmodule

// File: rtl/regbank_wb.sv
module regbank_wb #(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 3,
  parameter int READ_STAGE = 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cyc,
  input  logic                stb,
  input  logic                we,
  input  logic [ADDR_W-1:0]   adr,
  input  logic [DATA_W-1:0]   datIn,
  input  logic [DATA_W/8-1:0] sel,
  output logic                ack,
  output logic                stall,
  output logic [DATA_W-1:0]   datOut,
  input  logic [DATA_W-1:0]   statusIn,
  input  logic [DATA_W-1:0]   ioIn,
  output logic [DATA_W-1:0]   ctrlOut,
  output logic [DATA_W-1:0]   cmdOut,
  output logic [DATA_W-1:0]   ioOut,
  output logic                ctrlWr,
  output logic                cmdWr
);

  regbank_pkg::ctlStrobes_t ctl;

  regbank_ctrl #(.READ_STAGE(READ_STAGE)) u_ctrl (
    .clk(clk), .rstN(rstN), .cyc(cyc), .stb(stb), .we(we),
    .ack(ack), .stall(stall), .ctl(ctl)
  );

  regbank_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .READ_STAGE(READ_STAGE)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .adr(adr), .datIn(datIn), .sel(sel),
    .statusIn(statusIn), .ioIn(ioIn), .datOut(datOut),
    .ctrlOut(ctrlOut), .cmdOut(cmdOut), .ioOut(ioOut),
    .ctrlWr(ctrlWr), .cmdWr(cmdWr)
  );

endmodule

// File: rtl/regbank_chk.sv
module regbank_chk #(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 3,
  parameter int READ_STAGE = 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              cyc,
  input logic              stb,
  input logic              we,
  input logic [ADDR_W-1:0] adr,
  input logic              ack,
  input logic              stall,
  input logic [DATA_W-1:0] ctrlOut,
  input logic              ctrlWr,
  input logic              cmdWr
);

  logic busEn;
  assign busEn = cyc && stb;

  // R12
  p_stall_r12: assert property (@(posedge clk) disable iff (!rstN)
    (busEn && !ack) |-> stall);
  p_nostall_r12: assert property (@(posedge clk) disable iff (!rstN)
    (!busEn || ack) |-> !stall);

  // R11
  p_ack_once_r11: assert property (@(posedge clk) disable iff (!rstN)
    ack |=> !ack);
  p_ack_after_req_r11: assert property (@(posedge clk) disable iff (!rstN)
    ack |-> $past(busEn));

  // R2
  p_wr_ack_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busEn && we && !ack && !$past(busEn)) |=> ack);

  // R9
  p_ctrl_strobe_r9: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWr |-> (ack && !cmdWr));
  p_cmd_strobe_r9: assert property (@(posedge clk) disable iff (!rstN)
    cmdWr |=> !cmdWr);

  // R5, R10: writes outside offset 1 leave the control word alone
  p_ctrl_kept_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busEn && we && !ack && adr != ADDR_W'(1)) |=> $stable(ctrlOut));

  // R3
  generate
    if (READ_STAGE != 0) begin : g_rdLat2
      p_rd_lat_r3: assert property (@(posedge clk) disable iff (!rstN)
        $rose(busEn && !we) |=> (!ack ##1 ack));
    end else begin : g_rdLat1
      p_rd_lat_r3: assert property (@(posedge clk) disable iff (!rstN)
        $rose(busEn && !we) |=> ack);
    end
  endgenerate

endmodule

bind regbank_wb regbank_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .READ_STAGE(READ_STAGE)) u_chk (
  .clk(clk), .rstN(rstN), .cyc(cyc), .stb(stb), .we(we), .adr(adr),
  .ack(ack), .stall(stall), .ctrlOut(ctrlOut), .ctrlWr(ctrlWr), .cmdWr(cmdWr)
);

// File: tb/regbank_wb_test.sv
module regbank_wb_test;

  localparam int DW = 32;
  localparam int AW = 3;
  localparam int BW = DW / 8;

  logic clk = 1'b0;
  logic rstN;
  logic cyc, stb, stbF, we;
  logic [AW-1:0] adr;
  logic [DW-1:0] datIn, statusIn, ioIn;
  logic [BW-1:0] sel;

  logic ack, stall, ctrlWr, cmdWr;
  logic [DW-1:0] datOut, ctrlOut, cmdOut, ioOut;
  logic ackF, stallF, ctrlWrF, cmdWrF;
  logic [DW-1:0] datOutF, ctrlOutF, cmdOutF, ioOutF;

  int vectors = 0;
  int miscompares = 0;
  logic [DW-1:0] ctrlM, cmdM, ioM;

  always #2 clk = ~clk;

  regbank_wb #(.DATA_W(DW), .ADDR_W(AW), .READ_STAGE(1)) uut (
    .clk(clk), .rstN(rstN), .cyc(cyc), .stb(stb), .we(we), .adr(adr),
    .datIn(datIn), .sel(sel), .ack(ack), .stall(stall), .datOut(datOut),
    .statusIn(statusIn), .ioIn(ioIn), .ctrlOut(ctrlOut), .cmdOut(cmdOut),
    .ioOut(ioOut), .ctrlWr(ctrlWr), .cmdWr(cmdWr)
  );

  regbank_wb #(.DATA_W(DW), .ADDR_W(AW), .READ_STAGE(0)) uutFast (
    .clk(clk), .rstN(rstN), .cyc(cyc), .stb(stbF), .we(we), .adr(adr),
    .datIn(datIn), .sel(sel), .ack(ackF), .stall(stallF), .datOut(datOutF),
    .statusIn(statusIn), .ioIn(ioIn), .ctrlOut(ctrlOutF), .cmdOut(cmdOutF),
    .ioOut(ioOutF), .ctrlWr(ctrlWrF), .cmdWr(cmdWrF)
  );

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old, input logic [DW-1:0] nw,
                                          input logic [BW-1:0] s);
    logic [DW-1:0] r = old;
    for (int k = 0; k < BW; k++) if (s[k]) r[8*k +: 8] = nw[8*k +: 8];
    return r;
  endfunction

  function automatic logic [DW-1:0] expRead(input logic [AW-1:0] a);
    case (a)
      0: return statusIn;
      1: return ctrlM;
      3: return ioIn;
      default: return '0;
    endcase
  endfunction

  task automatic checkWords(input string tag);
    check({tag, " ctrlOut"}, ctrlOut, ctrlM);
    check({tag, " cmdOut"}, cmdOut, cmdM);
    check({tag, " ioOut"}, ioOut, ioM);
    check({tag, " ctrlOutF"}, ctrlOutF, ctrlM);
    check({tag, " cmdOutF"}, cmdOutF, cmdM);
    check({tag, " ioOutF"}, ioOutF, ioM);
  endtask

  task automatic busWrite(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [BW-1:0] s);
    @(negedge clk);
    cyc = 1; stb = 1; stbF = 1; we = 1; adr = a; datIn = d; sel = s;
    #1 check("R12 stall before ack", stall, 1);
    @(posedge clk); #1;
    check("R2 write ack", ack, 1);
    check("R2 write ack fast", ackF, 1);
    check("R12 stall in ack cycle", stall, 0);
    check("R9 ctrlWr pulse", ctrlWr, (a == 1));
    check("R9 cmdWr pulse", cmdWr, (a == 2));
    check("R9 ctrlWrF pulse", ctrlWrF, (a == 1));
    if (a == 1) ctrlM = merge(ctrlM, d, s);
    if (a == 2) cmdM  = merge(cmdM, d, s);
    if (a == 3) ioM   = merge(ioM, d, s);
    checkWords("R4 R5 R6 R7 R8 R10 write");
    @(negedge clk);
    cyc = 0; stb = 0; stbF = 0;
    @(posedge clk); #1;
    check("R11 single write ack", ack, 0);
    check("R9 ctrlWr one cycle", ctrlWr, 0);
    check("R9 cmdWr one cycle", cmdWr, 0);
  endtask

  task automatic busRead(input logic [AW-1:0] a);
    logic [DW-1:0] e;
    @(negedge clk);
    statusIn = $urandom; ioIn = $urandom;
    cyc = 1; stb = 1; stbF = 1; we = 0; adr = a; sel = BW'($urandom);
    e = expRead(a);
    #1 check("R12 stall on read", stall, 1);
    @(posedge clk); #1;
    check("R3 fast read ack", ackF, 1);
    check("R3 R5 R6 R7 R8 R10 fast read data", datOutF, e);
    check("R3 staged read not yet", ack, 0);
    check("R12 stall during stage", stall, 1);
    @(negedge clk);
    stbF = 0;
    @(posedge clk); #1;
    check("R3 staged read ack", ack, 1);
    check("R3 R5 R6 R7 R8 R10 staged read data", datOut, e);
    check("R11 fast ack once", ackF, 0);
    check("R12 stall low at ack", stall, 0);
    @(negedge clk);
    cyc = 0; stb = 0;
    @(posedge clk); #1;
    check("R11 staged ack once", ack, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rstN = 0; cyc = 0; stb = 0; stbF = 0; we = 0; adr = '0; datIn = '0; sel = '0;
    statusIn = 32'h1357_9bdf; ioIn = 32'h2468_ace0;
    ctrlM = '0; cmdM = '0; ioM = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 ack in reset", ack, 0);
    check("R1 datOut in reset", datOut, 0);
    check("R1 ctrlWr in reset", ctrlWr, 0);
    checkWords("R1 reset");
    @(negedge clk); rstN = 1;
    @(posedge clk); #1;
    check("R1 ack after reset", ack, 0);
    check("R1 cmdWr after reset", cmdWr, 0);

    // directed corners
    busWrite(1, 32'hdead_beef, 4'hf);          // R7 full write
    busRead(1);
    busWrite(1, 32'h1122_3344, 4'b0101);       // R4 partial lanes
    busRead(1);
    busWrite(2, 32'hcafe_f00d, 4'hf);          // R6
    busRead(2);
    busWrite(2, 32'h0, 4'h0);                  // R9 strobe with no lanes
    busWrite(0, 32'hffff_ffff, 4'hf);          // R5 ignored
    busRead(0);
    busWrite(3, 32'h0bad_c0de, 4'b1001);       // R8
    busRead(3);
    busWrite(5, 32'hffff_ffff, 4'hf);          // R10 ignored
    busRead(7);                                // R10 zero
    busRead(4);

    for (int i = 0; i < 400; i++) begin
      logic [AW-1:0] a = AW'($urandom);
      if ($urandom % 2) busWrite(a, $urandom, BW'($urandom));
      else              busRead(a);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule